// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits next to a small 32-bit CPU core and decides, cycle by cycle, whether the core must abandon its current instruction stream and jump to a handler. It watches a reset request, one non-maskable interrupt line and a parameterised set of maskable request lines (six by default). When it accepts an event it raises a one-clock redirect strobe together with the handler address. In the same clock edge it updates the status word, the context-save registers and the cause register.

The status word carries three control flags: interrupt-disable, exception-in-progress and NMI-in-progress. The NMI-in-progress flag holds back further non-maskable events. Those events collapse into a single held request, which is retried every cycle. Either the NMI-in-progress flag or the disable flag holds back maskable requests. A maskable requester keeps its line high until it sees its accept pulse. A plain write port loads the status word whenever no event is being accepted.

Top module: `irq_entry_ctrl`

## Requirements
- R1: In a cycle with `rst_req` high, the next cycle shows `redirect`=1, `target`=0, `psw`=0x20 and `ecr`=0. This overrides any NMI, maskable request or status write in that cycle and drops a held NMI. The save registers are left unchanged.
- R2: An NMI event is accepted only when status bit 7 (NMI-in-progress) is clear. An NMI event is `nmi_in` high or a held NMI. On acceptance, `fepc` takes `cur_pc` and `fepsw` takes the old `psw`. Bit 7 and bit 5 (disable) are set and bit 6 (exception-in-progress) is cleared. The target is 0x10.
- R3: On NMI acceptance, `ecr` becomes {16'h0000, old `ecr`[15:0] | 16'h0010}.
- R4: If `nmi_in` is high while bit 7 is set, one NMI is held. Any number of further pulses before delivery merge into it. If a held NMI is delivered in a cycle where `nmi_in` is also high, one NMI stays held.
- R5: While status bit 7 or bit 5 is set, no maskable request is accepted and every `irq_ack` bit is 0. The request simply waits.
- R6: On maskable acceptance, `eipc` takes `cur_pc` and `eipsw` takes the old `psw`. Bit 5 is set and bit 6 is cleared. `ecr`[15:0] takes the source code and `ecr`[31:16] is kept.
- R7: Maskable source i has vector and cause code 0x80 + 0x10*i, so the default sources use 0x80 to 0xD0.
- R8: A status write (`psw_we`) stores `psw_wdata` & 0xFF, with bits Z=0, S=1, OV=2, CY=3, SAT=4, ID=5, EP=6, NP=7. It is ignored in any cycle where an event is accepted.
- R9: The priority order is reset first, then NMI, then the maskable source with the lowest index. At most one event is accepted per cycle. `irq_ack` is combinational, at most one bit high, and only for a requesting line.
- R10: `redirect` is high for exactly the one cycle after each accepting cycle, and low in every other cycle.
- R11: After `rst_n` is released, before any event, `psw`=0x20, `redirect`=0 and all other registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset request event |
| nmi_in | input | 1 | Non-maskable event, one event per high cycle |
| irq_req | input | N_IRQ | Level-held maskable requests |
| cur_pc | input | PC_W | Core's current program counter |
| psw_we | input | 1 | Status word write enable |
| psw_wdata | input | PSW_W | Status word write data |
| redirect | output | 1 | One-cycle jump strobe |
| target | output | PC_W | Handler address, valid with redirect |
| irq_ack | output | N_IRQ | Per-source accept pulse |
| psw | output | PSW_W | Status word |
| eipc | output | PC_W | Saved PC for maskable entry |
| eipsw | output | PSW_W | Saved status for maskable entry |
| fepc | output | PC_W | Saved PC for NMI entry |
| fepsw | output | PSW_W | Saved status for NMI entry |
| ecr | output | 32 | Cause register |

## Verification
The hardest situation to reach is a held NMI that waits behind an NMI already in service. Several further NMI pulses must merge into that one held request, and after delivery no second handler entry may follow. The ports give no direct view of the held request. The stimulus creates the situation by accepting one NMI, pulsing `nmi_in` several times while bit 7 is set, and then clearing bit 7 with a status write. Exactly one delayed redirect must appear, and no second one after bit 7 is cleared again. Random traffic then mixes status writes that toggle bits 7 and 5 with NMI pulses and overlapping maskable requests, so every blocking combination recurs.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   // status word bit positions
   localparam int PSW_Z   = 0;
   localparam int PSW_S   = 1;
   localparam int PSW_OV  = 2;
   localparam int PSW_CY  = 3;
   localparam int PSW_SAT = 4;
   localparam int PSW_ID  = 5;
   localparam int PSW_EP  = 6;
   localparam int PSW_NP  = 7;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_RESET = 2'd1,
      EV_NMI   = 2'd2,
      EV_MASK  = 2'd3
   } entry_ev_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Fixed priority: lowest index wins.
module irq_prio_pick #(
   parameter int N = 6,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (req[i]) idx = IW'(i);
   end
endmodule

// File: rtl/irq_vec_table.sv
// Handler vector per maskable source: BASE + STEP*index.
module irq_vec_table #(
   parameter int N    = 6,
   parameter int W    = 32,
   parameter int BASE = 'h80,
   parameter int STEP = 'h10,
   localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
   input  logic [IW-1:0] idx,
   output logic [W-1:0]  vec
);
   logic [W-1:0] tbl [N];

   for (genvar i = 0; i < N; i++) begin : g_ent
      assign tbl[i] = W'(BASE + STEP * i);
   end

   always_comb begin
      vec = '0;
      for (int i = 0; i < N; i++)
         if (idx == IW'(i)) vec = tbl[i];
   end
endmodule

// File: rtl/irq_nmi_hold.sv
// Single held NMI request; extra pulses merge into it.
module irq_nmi_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic nmi_in,
   input  logic take,
   output logic want
);
   logic pend_q;

   assign want = nmi_in | pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (clr)    pend_q <= 1'b0;
      else if (take)   pend_q <= pend_q & nmi_in;
      else if (want)   pend_q <= 1'b1;
   end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
   import irq_entry_pkg::*;
#(
   parameter int N_IRQ     = 6,
   parameter int PC_W      = 32,
   parameter int PSW_W     = 32,
   parameter int ECR_W     = 32,
   parameter int NMI_VEC   = 'h10,
   parameter int NMI_CODE  = 'h10,
   parameter int VEC_BASE  = 'h80,
   parameter int VEC_STEP  = 'h10,
   parameter int PSW_RST   = 'h20,
   parameter int PSW_WMASK = 'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req,
   input  logic              nmi_in,
   input  logic [N_IRQ-1:0]  irq_req,
   input  logic [PC_W-1:0]   cur_pc,
   input  logic              psw_we,
   input  logic [PSW_W-1:0]  psw_wdata,
   output logic              redirect,
   output logic [PC_W-1:0]   target,
   output logic [N_IRQ-1:0]  irq_ack,
   output logic [PSW_W-1:0]  psw,
   output logic [PC_W-1:0]   eipc,
   output logic [PSW_W-1:0]  eipsw,
   output logic [PC_W-1:0]   fepc,
   output logic [PSW_W-1:0]  fepsw,
   output logic [ECR_W-1:0]  ecr
);
   localparam int IW   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
   localparam int HALF = ECR_W / 2;
   localparam int VMAX = VEC_BASE + VEC_STEP * (N_IRQ - 1);
   localparam logic [HALF-1:0]  NMI_CODE_H = HALF'(NMI_CODE);
   localparam logic [PSW_W-1:0] WMASK      = PSW_W'(PSW_WMASK);

   // elaboration-time parameter checks
   if (N_IRQ < 1) begin : g_bad_n
      $error("N_IRQ must be at least 1");
   end
   if (PSW_W <= PSW_NP) begin : g_bad_psw
      $error("PSW_W too narrow for the flag bits");
   end
   if ((ECR_W % 2) != 0 || HALF < 8) begin : g_bad_ecr
      $error("ECR_W must be even and at least 16");
   end
   if (VMAX >= (1 << HALF)) begin : g_bad_vec
      $error("maskable codes do not fit in half of ECR");
   end

   logic [N_IRQ-1:0] gnt;
   logic [IW-1:0]    gidx;
   logic [PC_W-1:0]  mvec;
   logic             nmi_want, nmi_take, irq_ok;
   entry_ev_e        ev;

   irq_prio_pick #(.N(N_IRQ)) u_pick (
      .req (irq_req),
      .gnt (gnt),
      .idx (gidx)
   );

   irq_vec_table #(.N(N_IRQ), .W(PC_W), .BASE(VEC_BASE), .STEP(VEC_STEP)) u_vec (
      .idx (gidx),
      .vec (mvec)
   );

   irq_nmi_hold u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (rst_req),
      .nmi_in (nmi_in),
      .take   (nmi_take),
      .want   (nmi_want)
   );

   always_comb begin
      nmi_take = nmi_want & ~psw[PSW_NP] & ~rst_req;
      irq_ok   = ~rst_req & ~nmi_take & ~psw[PSW_NP] & ~psw[PSW_ID];
      irq_ack  = irq_ok ? gnt : '0;
      if (rst_req)       ev = EV_RESET;
      else if (nmi_take) ev = EV_NMI;
      else if (|irq_ack) ev = EV_MASK;
      else               ev = EV_NONE;
   end

   // status word with the common entry edits applied
   logic [PSW_W-1:0] psw_ent;
   always_comb begin
      psw_ent         = psw;
      psw_ent[PSW_ID] = 1'b1;
      psw_ent[PSW_EP] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect <= 1'b0;
         target   <= '0;
         psw      <= PSW_W'(PSW_RST);
         eipc     <= '0;
         eipsw    <= '0;
         fepc     <= '0;
         fepsw    <= '0;
         ecr      <= '0;
      end else begin
         redirect <= (ev != EV_NONE);
         unique case (ev)
            EV_RESET: begin
               target <= '0;
               psw    <= PSW_W'(PSW_RST);
               ecr    <= '0;
            end
            EV_NMI: begin
               target       <= PC_W'(NMI_VEC);
               fepc         <= cur_pc;
               fepsw        <= psw;
               psw          <= psw_ent;
               psw[PSW_NP]  <= 1'b1;
               ecr          <= {{(ECR_W-HALF){1'b0}}, ecr[HALF-1:0] | NMI_CODE_H};
            end
            EV_MASK: begin
               target <= mvec;
               eipc   <= cur_pc;
               eipsw  <= psw;
               psw    <= psw_ent;
               ecr    <= {ecr[ECR_W-1:HALF], mvec[HALF-1:0]};
            end
            default: begin
               if (psw_we) psw <= psw_wdata & WMASK;
            end
         endcase
      end
   end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
   import irq_entry_pkg::*;
#(
   parameter int N_IRQ   = 6,
   parameter int PC_W    = 32,
   parameter int PSW_W   = 32,
   parameter int ECR_W   = 32,
   parameter int NMI_VEC = 'h10,
   parameter int PSW_RST = 'h20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rst_req,
   input logic             nmi_in,
   input logic [N_IRQ-1:0] irq_req,
   input logic [PC_W-1:0]  cur_pc,
   input logic             redirect,
   input logic [PC_W-1:0]  target,
   input logic [N_IRQ-1:0] irq_ack,
   input logic [PSW_W-1:0] psw,
   input logic [PC_W-1:0]  eipc,
   input logic [ECR_W-1:0] ecr
);
   p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   p_ack_only_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack & ~irq_req) == '0);

   p_mask_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (psw[PSW_NP] || psw[PSW_ID]) |-> irq_ack == '0);

   p_ack_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |=> redirect);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && !nmi_in && irq_req == '0 && psw[PSW_NP]) |=> !redirect);

   p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (redirect && target == '0 && psw == PSW_W'(PSW_RST) && ecr == '0));

   p_nmi_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_in && !psw[PSW_NP] && !rst_req) |=>
         (redirect && target == PC_W'(NMI_VEC) && psw[PSW_NP] && psw[PSW_ID]));

   p_eipc_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |=> (eipc == $past(cur_pc) && psw[PSW_ID] && !psw[PSW_EP]));
endmodule

bind irq_entry_ctrl irq_entry_chk #(
   .N_IRQ(N_IRQ), .PC_W(PC_W), .PSW_W(PSW_W), .ECR_W(ECR_W),
   .NMI_VEC(NMI_VEC), .PSW_RST(PSW_RST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_in(nmi_in),
   .irq_req(irq_req), .cur_pc(cur_pc), .redirect(redirect), .target(target),
   .irq_ack(irq_ack), .psw(psw), .eipc(eipc), .ecr(ecr)
);

// File: tb/sim_irq_entry_ctrl.sv
`timescale 1ns/1ps
module sim_irq_entry_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 1'b0;
   logic        nmi_in = 1'b0;
   logic [5:0]  irq_req = '0;
   logic [31:0] cur_pc = '0;
   logic        psw_we = 1'b0;
   logic [31:0] psw_wdata = '0;
   logic        redirect;
   logic [31:0] target;
   logic [5:0]  irq_ack;
   logic [31:0] psw, eipc, eipsw, fepc, fepsw, ecr;

   irq_entry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_in(nmi_in),
      .irq_req(irq_req), .cur_pc(cur_pc), .psw_we(psw_we), .psw_wdata(psw_wdata),
      .redirect(redirect), .target(target), .irq_ack(irq_ack), .psw(psw),
      .eipc(eipc), .eipsw(eipsw), .fepc(fepc), .fepsw(fepsw), .ecr(ecr)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int redirects = 0;
   bit done = 1'b0;

   // reference state
   logic        m_redir;
   logic [31:0] m_tgt, m_psw, m_eipc, m_eipsw, m_fepc, m_fepsw, m_ecr;
   logic        m_pend;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [5:0] exp_ack(input logic r, input logic n, input logic [5:0] q);
      logic [5:0] a = '0;
      if (!r && !((n || m_pend) && !m_psw[7]) && !m_psw[7] && !m_psw[5])
         for (int i = 0; i < 6; i++)
            if (q[i] && a == '0) a[i] = 1'b1;
      return a;
   endfunction

   function automatic int lowest(input logic [5:0] a);
      for (int i = 0; i < 6; i++) if (a[i]) return i;
      return 0;
   endfunction

   task automatic model_reset();
      m_redir = 0; m_tgt = 0; m_psw = 32'h20; m_eipc = 0; m_eipsw = 0;
      m_fepc = 0; m_fepsw = 0; m_ecr = 0; m_pend = 0;
   endtask

   task automatic model_step(input logic r, input logic n, input logic [5:0] q,
                             input logic [31:0] pc, input logic we, input logic [31:0] wd);
      logic [5:0] a;
      logic       ev;
      a  = exp_ack(r, n, q);
      ev = n | m_pend;
      m_redir = 1'b0;
      if (r) begin
         m_redir = 1; m_tgt = 0; m_psw = 32'h20; m_ecr = 0; m_pend = 0;
      end else if (ev && !m_psw[7]) begin
         m_redir = 1; m_tgt = 32'h10; m_fepc = pc; m_fepsw = m_psw;
         m_psw = (m_psw | 32'hA0) & ~32'h40;
         m_ecr = {16'h0, m_ecr[15:0] | 16'h0010};
         m_pend = m_pend & n;
      end else if (a != '0) begin
         m_redir = 1; m_tgt = 32'h80 + 32'h10 * lowest(a);
         m_eipc = pc; m_eipsw = m_psw;
         m_psw = (m_psw | 32'h20) & ~32'h40;
         m_ecr = {m_ecr[31:16], m_tgt[15:0]};
      end else begin
         if (ev) m_pend = 1'b1;
         if (we) m_psw = wd & 32'hFF;
      end
   endtask

   task automatic compare_all(input string tag);
      chk({"R10 redirect ", tag}, {31'b0, redirect}, {31'b0, m_redir});
      if (m_redir) chk({"R7 target ", tag}, target, m_tgt);
      chk({"R8 psw ", tag}, psw, m_psw);
      chk({"R6 eipc ", tag}, eipc, m_eipc);
      chk({"R6 eipsw ", tag}, eipsw, m_eipsw);
      chk({"R2 fepc ", tag}, fepc, m_fepc);
      chk({"R2 fepsw ", tag}, fepsw, m_fepsw);
      chk({"R3 ecr ", tag}, ecr, m_ecr);
   endtask

   task automatic cyc(input string tag, input logic r, input logic n, input logic [5:0] q,
                      input logic [31:0] pc, input logic we, input logic [31:0] wd);
      @(negedge clk);
      rst_req = r; nmi_in = n; irq_req = q; cur_pc = pc; psw_we = we; psw_wdata = wd;
      #1;
      chk({"R9 ack ", tag}, {26'b0, irq_ack}, {26'b0, exp_ack(r, n, q)});
      @(posedge clk);
      model_step(r, n, q, pc, we, wd);
      #1;
      if (redirect) redirects++;
      compare_all(tag);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int r0;
      logic [5:0] hold;
      void'($urandom(32'h1F2E3D4C));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      compare_all("R11 after power-up");
      @(negedge clk); rst_n = 1'b1;
      #1;
      compare_all("R11 released");

      // R8: masked write, then clear all flags
      cyc("R8 write", 0, 0, 0, 32'h100, 1, 32'hFFFF_FFFF);
      cyc("R8 clear", 0, 0, 0, 32'h104, 1, 32'h0);
      // R9: all sources together -> source 0; R7 vector 0x80
      cyc("R9 all", 0, 0, 6'h3F, 32'h200, 0, 0);
      // R5: disable set, request waits
      cyc("R5 blocked", 0, 0, 6'h3E, 32'h204, 0, 0);
      cyc("R5 unblock", 0, 0, 6'h3E, 32'h208, 1, 32'h0);
      cyc("R7 src1", 0, 0, 6'h3E, 32'h20C, 0, 0);
      // R8: write ignored while an event is taken
      cyc("R8 clr", 0, 0, 0, 32'h210, 1, 32'h0);
      cyc("R8 ignored", 0, 0, 6'h20, 32'h214, 1, 32'h0F);
      // R9: NMI beats maskable
      cyc("R9 clr", 0, 0, 0, 32'h218, 1, 32'h0);
      cyc("R9 nmi first", 0, 1, 6'h01, 32'h300, 0, 0);
      // R4: NMIs during service merge into one held request
      cyc("R4 p1", 0, 1, 0, 32'h304, 0, 0);
      cyc("R4 p2", 0, 1, 0, 32'h308, 0, 0);
      cyc("R4 p3", 0, 1, 0, 32'h30C, 0, 0);
      cyc("R4 np clr", 0, 0, 0, 32'h310, 1, 32'h0);
      cyc("R4 deliver", 0, 0, 0, 32'h314, 0, 0);
      cyc("R4 np clr2", 0, 0, 0, 32'h318, 1, 32'h0);
      cyc("R4 no second", 0, 0, 0, 32'h31C, 0, 0);
      chk("R4 no second redirect", {31'b0, redirect}, 32'h0);
      // R1: reset request overrides everything
      cyc("R1 override", 1, 1, 6'h3F, 32'h400, 1, 32'hFF);
      cyc("R1 after", 0, 0, 0, 32'h404, 0, 0);

      // constrained random phase
      hold = '0;
      for (int k = 0; k < 4000; k++) begin
         logic r, n, we;
         logic [31:0] wd;
         r0   = $urandom;
         hold = (hold & ~irq_ack) | (($urandom % 4 == 0) ? 6'($urandom) : 6'h0);
         r    = ($urandom % 80) == 0;
         n    = ($urandom % 12) == 0;
         we   = ($urandom % 4) == 0;
         wd   = $urandom;
         cyc("random", r, n, hold, 32'(r0), we, wd);
         if (r) hold = '0;
      end

      chk("R10 redirects seen", {31'b0, redirects > 100}, 32'h1);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule